// File: doc/BRIEF.md
# Interrupt Entry and Registration Sequencer

This block runs the startup and interrupt-entry sequences for a small CPU with 8-bit data and a byte-wide memory port. After reset it reads a 16-bit start address from the two lowest memory bytes and hands it to the core as a PC load. When an interrupt is taken, it reads the stack base and the handler address from their fixed memory slots again. It writes the interrupted PC to the stack and loads the handler address. It then sets the interrupt-type and interrupt-data registers and turns on the banked-register enable.

The core drives it through a held request with a one-cycle acknowledge. The request operations are: software interrupt, invalid-instruction trap, global enable, global disable, and registration. Registration hands out interrupt identifiers 1 to 15. Each identifier carries a flag that lets software raise it and a flag that lets the bus raise it. Identifier 0 is the invalid-instruction trap. Any event that arrives while interrupts are disabled is held pending. When interrupts are enabled again, the pending events are taken lowest identifier first.

Memory reads return data in the cycle after the read strobe. Vectors are little-endian: the low byte is at the lower address.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block reads address 0x0000 and then 0x0001, with no other memory traffic. It then pulses pcLoad with pcValue = {byte1, byte0} and drops busy.
- R2: While reset is held, irqEnable, bankEn, intType, intData and stackPtr are all zero.
- R3: A registration request (reqOp=1) is acknowledged in the cycle after it is presented. reqResult is the lowest free identifier in 1..15, with reqArg bit 0 = software may raise it and bit 1 = bus may raise it. When all 15 are taken the result is 0xFF.
- R4: Every entry performs, one per cycle, reads of 0x0002, 0x0003, 0x0004 and 0x0005. It then writes the resume PC low byte to stackBase+stackPtr and the high byte to the next address, where stackBase = {byte3, byte2}. stackPtr grows by one per byte. pcLoad with pcValue = {byte5, byte4} coincides with the second write.
- R5: On entry completion, intType = id << 4 with bits 3..0 zero, bankEn becomes 1 and irqEnable becomes 0.
- R6: A bus-raised entry loads intData with the byte captured from busIrqData. Any other entry leaves intData unchanged.
- R7: A software interrupt (reqOp=0, id in reqArg) that is permitted and enabled is acknowledged six cycles after the cycle it is presented in, together with the second stack write.
- R8: A request is ignored when its id is unregistered, lacks the flag for its source, or has reqArg bits 7..4 nonzero. A software request is then acknowledged in its presentation cycle with no memory traffic. A bus event causes no entry.
- R9: A permitted event that arrives while interrupts are disabled is held pending. A software request is acknowledged at once. Once enabled and idle with no request presented, the lowest pending id is entered.
- R10: The invalid-instruction trap (reqOp=4) uses id 0, needs no registration, and follows R7 and R9 timing.
- R11: Disable (reqOp=2) and enable (reqOp=3) are acknowledged in their presentation cycle and clear or set irqEnable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request, held until reqAck |
| reqOp | input | 3 | 0 soft irq, 1 register, 2 disable, 3 enable, 4 invalid-instruction trap |
| reqArg | input | 8 | Id for soft irq, flag byte for registration |
| reqAck | output | 1 | One-cycle request acknowledge |
| reqResult | output | 8 | Registration result, valid with reqAck |
| curPc | input | 16 | Resume address to push on entry |
| busIrq | input | 1 | One-cycle bus interrupt event |
| busIrqId | input | 4 | Id raised by the bus |
| busIrqData | input | 8 | Byte delivered with the bus event |
| memAddr | output | 16 | Memory address |
| memRd | output | 1 | Read strobe, data next cycle |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data |
| pcLoad | output | 1 | Load pcValue into the core PC |
| pcValue | output | 16 | Start or handler address |
| stackPtr | output | 8 | Stack offset register |
| intType | output | 8 | Interrupt type, id in bits 7..4 |
| intData | output | 8 | Interrupt data byte |
| bankEn | output | 1 | Interrupt-reserved register access |
| irqEnable | output | 1 | Global interrupt enable |
| busy | output | 1 | Sequencer not idle |

## Verification
The bench uses the default parameters: 16 identifiers, 8-bit data, 16-bit addresses and vector slots at 0, 2 and 4. With these values all fifteen allocatable ids can be exhausted in a short run, so the 0xFF failure result is reached. The stack base byte is rewritten between entries, which shows that the vectors are read again each time. Bus and software events are mixed while interrupts are disabled to exercise lowest-id dispatch and intData retention.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    OP_SWI = 3'd0,
    OP_REG = 3'd1,
    OP_DIS = 3'd2,
    OP_ENA = 3'd3,
    OP_ILL = 3'd4
  } reqOp_e;

  typedef enum logic [2:0] {
    AS_START_LO,
    AS_START_HI,
    AS_STK_LO,
    AS_STK_HI,
    AS_VEC_LO,
    AS_VEC_HI,
    AS_PUSH
  } addrSel_e;

  typedef struct packed {
    logic     memRd;
    logic     memWr;
    addrSel_e addrSel;
    logic     capTgtLo;
    logic     capTgtHi;
    logic     capStkLo;
    logic     capStkHi;
    logic     pushHi;
    logic     spInc;
    logic     startEntry;
    logic     commit;
    logic     pcLoad;
  } strobe_t;

endpackage

// File: rtl/irq_slot_table.sv
module irq_slot_table #(
  parameter int NUM_IDS = 16,
  parameter int ID_W    = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocDo,
  input  logic [1:0]        allocCfg,
  input  logic [ID_W-1:0]   swId,
  input  logic              busIrq,
  input  logic [ID_W-1:0]   busId,
  input  logic [DATA_W-1:0] busData,
  input  logic              setPendSw,
  input  logic [ID_W-1:0]   setPendId,
  input  logic              clrPend,
  input  logic [ID_W-1:0]   clrPendId,
  output logic              allocOk,
  output logic [ID_W-1:0]   allocId,
  output logic              swAllowed,
  output logic              pendAny,
  output logic [ID_W-1:0]   pendId,
  output logic [DATA_W-1:0] pendData,
  output logic              pendHasData
);

  logic [NUM_IDS-1:0] used, alSw, alBus, pend, pendBus;
  logic [DATA_W-1:0]  pendDat [NUM_IDS];
  logic [NUM_IDS-1:0] allocHit, setHit, clrHit, busHit;

  for (genvar g = 0; g < NUM_IDS; g++) begin : gDecode
    assign allocHit[g] = allocDo && (allocId == ID_W'(g));
    assign setHit[g]   = setPendSw && (setPendId == ID_W'(g));
    assign clrHit[g]   = clrPend && (clrPendId == ID_W'(g));
    assign busHit[g]   = busIrq && (busId == ID_W'(g)) && alBus[g];
  end

  always_comb begin
    allocId = '0;
    allocOk = 1'b0;
    for (int i = NUM_IDS - 1; i >= 1; i--) begin
      if (!used[i]) begin
        allocId = ID_W'(i);
        allocOk = 1'b1;
      end
    end
  end

  always_comb begin
    pendId = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (pend[i]) pendId = ID_W'(i);
    end
  end

  assign pendAny     = |pend;
  assign pendData    = pendDat[pendId];
  assign pendHasData = pendBus[pendId];
  assign swAllowed   = alSw[swId];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      used    <= NUM_IDS'(1);
      alSw    <= '0;
      alBus   <= '0;
      pend    <= '0;
      pendBus <= '0;
      for (int i = 0; i < NUM_IDS; i++) pendDat[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_IDS; i++) begin
        if (allocHit[i]) begin
          used[i]  <= 1'b1;
          alSw[i]  <= allocCfg[0];
          alBus[i] <= allocCfg[1];
        end
        if (clrHit[i]) pend[i] <= 1'b0;
        if (setHit[i]) begin
          pend[i]    <= 1'b1;
          pendBus[i] <= 1'b0;
        end
        if (busHit[i]) begin
          pend[i]    <= 1'b1;
          pendBus[i] <= 1'b1;
          pendDat[i] <= busData;
        end
      end
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rstN)
    allocDo |-> (!used[allocId] && allocId != '0)) else $error("alloc of used id"); // R3

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int NUM_IDS = 16,
  parameter int ID_W    = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [DATA_W-1:0] reqArg,
  input  logic              swAllowed,
  input  logic              pendAny,
  input  logic [ID_W-1:0]   pendId,
  input  logic [DATA_W-1:0] pendData,
  input  logic              pendHasData,
  input  logic              allocOk,
  input  logic [ID_W-1:0]   allocId,
  output strobe_t           st,
  output logic              reqAck,
  output logic [DATA_W-1:0] reqResult,
  output logic              irqEnable,
  output logic              busy,
  output logic [ID_W-1:0]   entryId,
  output logic [DATA_W-1:0] entryData,
  output logic              entryHasData,
  output logic              setPendSw,
  output logic [ID_W-1:0]   setPendId,
  output logic              clrPend,
  output logic              allocDo
);

  typedef enum logic [3:0] {
    S_BOOT0, S_BOOT1, S_BOOT2, S_BOOT3, S_IDLE, S_REG,
    S_STK0, S_STK1, S_VEC0, S_VEC1, S_PUSH0, S_PUSH1
  } state_e;

  state_e state, nextState;
  logic   ena, enaSet, enaClr;
  logic   ackPend, ackPendNext;
  logic   argInRange, permitted;
  reqOp_e op;

  assign op         = reqOp_e'(reqOp);
  assign argInRange = (reqArg[DATA_W-1:ID_W] == '0);
  assign permitted  = (op == OP_ILL) || (argInRange && swAllowed);
  assign irqEnable  = ena;
  assign busy       = (state != S_IDLE);

  always_comb begin
    st           = '0;
    nextState    = state;
    reqAck       = 1'b0;
    reqResult    = '0;
    enaSet       = 1'b0;
    enaClr       = 1'b0;
    entryId      = '0;
    entryData    = '0;
    entryHasData = 1'b0;
    setPendSw    = 1'b0;
    setPendId    = '0;
    clrPend      = 1'b0;
    allocDo      = 1'b0;
    ackPendNext  = ackPend;
    unique case (state)
      S_BOOT0: begin st.memRd = 1'b1; st.addrSel = AS_START_LO; nextState = S_BOOT1; end
      S_BOOT1: begin
        st.memRd = 1'b1; st.addrSel = AS_START_HI; st.capTgtLo = 1'b1; nextState = S_BOOT2;
      end
      S_BOOT2: begin st.capTgtHi = 1'b1; nextState = S_BOOT3; end
      S_BOOT3: begin st.pcLoad = 1'b1; nextState = S_IDLE; end
      S_IDLE: begin
        if (reqValid) begin
          case (op)
            OP_ENA: begin reqAck = 1'b1; enaSet = 1'b1; end
            OP_DIS: begin reqAck = 1'b1; enaClr = 1'b1; end
            OP_REG: nextState = S_REG;
            OP_SWI, OP_ILL: begin
              if (!permitted) begin
                reqAck = 1'b1;
              end else if (!ena) begin
                reqAck    = 1'b1;
                setPendSw = 1'b1;
                setPendId = (op == OP_ILL) ? '0 : reqArg[ID_W-1:0];
              end else begin
                st.startEntry = 1'b1;
                entryId       = (op == OP_ILL) ? '0 : reqArg[ID_W-1:0];
                ackPendNext   = 1'b1;
                nextState     = S_STK0;
              end
            end
            default: reqAck = 1'b1;
          endcase
        end else if (ena && pendAny) begin
          st.startEntry = 1'b1;
          entryId       = pendId;
          entryData     = pendData;
          entryHasData  = pendHasData;
          clrPend       = 1'b1;
          ackPendNext   = 1'b0;
          nextState     = S_STK0;
        end
      end
      S_REG: begin
        reqAck    = 1'b1;
        allocDo   = allocOk;
        reqResult = allocOk ? DATA_W'(allocId) : '1;
        nextState = S_IDLE;
      end
      S_STK0: begin st.memRd = 1'b1; st.addrSel = AS_STK_LO; nextState = S_STK1; end
      S_STK1: begin
        st.memRd = 1'b1; st.addrSel = AS_STK_HI; st.capStkLo = 1'b1; nextState = S_VEC0;
      end
      S_VEC0: begin
        st.memRd = 1'b1; st.addrSel = AS_VEC_LO; st.capStkHi = 1'b1; nextState = S_VEC1;
      end
      S_VEC1: begin
        st.memRd = 1'b1; st.addrSel = AS_VEC_HI; st.capTgtLo = 1'b1; nextState = S_PUSH0;
      end
      S_PUSH0: begin
        st.memWr = 1'b1; st.addrSel = AS_PUSH; st.capTgtHi = 1'b1; st.spInc = 1'b1;
        nextState = S_PUSH1;
      end
      S_PUSH1: begin
        st.memWr  = 1'b1; st.addrSel = AS_PUSH; st.pushHi = 1'b1; st.spInc = 1'b1;
        st.commit = 1'b1; st.pcLoad = 1'b1;
        reqAck    = ackPend;
        enaClr    = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_BOOT0;
      ena     <= 1'b0;
      ackPend <= 1'b0;
    end else begin
      state   <= nextState;
      ackPend <= ackPendNext;
      if (enaSet)      ena <= 1'b1;
      else if (enaClr) ena <= 1'b0;
    end
  end

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> reqValid) else $error("ack without request"); // R7

  AST_REG_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && state == S_REG) |->
      (reqResult == '1 || (reqResult != '0 && reqResult < DATA_W'(NUM_IDS))))
    else $error("bad registration result"); // R3

  AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (st.memWr && !st.pushHi) |=> (st.memWr && st.pushHi && st.pcLoad))
    else $error("push pair broken"); // R4

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ID_W       = 4,
  parameter int START_ADDR = 0,
  parameter int STACK_ADDR = 2,
  parameter int VEC_ADDR   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ID_W-1:0]   entryId,
  input  logic [DATA_W-1:0] entryData,
  input  logic              entryHasData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcValue,
  output logic [DATA_W-1:0] stackPtr,
  output logic [DATA_W-1:0] intType,
  output logic [DATA_W-1:0] intData,
  output logic              bankEn
);

  localparam int TYPE_SH = DATA_W - ID_W;

  logic [ADDR_W-1:0] stkBase, target, resumePc;
  logic [ID_W-1:0]   entId;
  logic [DATA_W-1:0] entData;
  logic              entHasData;

  assign memRd   = st.memRd;
  assign memWr   = st.memWr;
  assign pcLoad  = st.pcLoad;
  assign pcValue = target;

  always_comb begin
    unique case (st.addrSel)
      AS_START_LO: memAddr = ADDR_W'(START_ADDR);
      AS_START_HI: memAddr = ADDR_W'(START_ADDR + 1);
      AS_STK_LO:   memAddr = ADDR_W'(STACK_ADDR);
      AS_STK_HI:   memAddr = ADDR_W'(STACK_ADDR + 1);
      AS_VEC_LO:   memAddr = ADDR_W'(VEC_ADDR);
      AS_VEC_HI:   memAddr = ADDR_W'(VEC_ADDR + 1);
      AS_PUSH:     memAddr = stkBase + ADDR_W'(stackPtr);
      default:     memAddr = '0;
    endcase
  end

  assign memWdata = st.pushHi ? resumePc[ADDR_W-1:DATA_W] : resumePc[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stkBase    <= '0;
      target     <= '0;
      resumePc   <= '0;
      entId      <= '0;
      entData    <= '0;
      entHasData <= 1'b0;
      stackPtr   <= '0;
      intType    <= '0;
      intData    <= '0;
      bankEn     <= 1'b0;
    end else begin
      if (st.capStkLo) stkBase[DATA_W-1:0]        <= memRdata;
      if (st.capStkHi) stkBase[ADDR_W-1:DATA_W]   <= memRdata;
      if (st.capTgtLo) target[DATA_W-1:0]         <= memRdata;
      if (st.capTgtHi) target[ADDR_W-1:DATA_W]    <= memRdata;
      if (st.spInc)    stackPtr                   <= stackPtr + 1'b1;
      if (st.startEntry) begin
        resumePc   <= curPc;
        entId      <= entryId;
        entData    <= entryData;
        entHasData <= entryHasData;
      end
      if (st.commit) begin
        intType <= DATA_W'(entId) << TYPE_SH;
        bankEn  <= 1'b1;
        if (entHasData) intData <= entData;
      end
    end
  end

  AST_COMMIT_BANK: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> (bankEn && intType[TYPE_SH-1:0] == '0)) else $error("entry commit"); // R5

  AST_PUSH_ADJ: assert property (@(posedge clk) disable iff (!rstN)
    (st.memWr && st.pushHi) |-> (memAddr == $past(memAddr) + 1'b1))
    else $error("push bytes not adjacent"); // R4

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_IDS    = 16,
  parameter int ID_W       = $clog2(NUM_IDS),
  parameter int START_ADDR = 0,
  parameter int STACK_ADDR = 2,
  parameter int VEC_ADDR   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [DATA_W-1:0] reqArg,
  output logic              reqAck,
  output logic [DATA_W-1:0] reqResult,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              busIrq,
  input  logic [ID_W-1:0]   busIrqId,
  input  logic [DATA_W-1:0] busIrqData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcValue,
  output logic [DATA_W-1:0] stackPtr,
  output logic [DATA_W-1:0] intType,
  output logic [DATA_W-1:0] intData,
  output logic              bankEn,
  output logic              irqEnable,
  output logic              busy
);

  strobe_t           st;
  logic              swAllowed, pendAny, pendHasData, allocOk, allocDo;
  logic              setPendSw, clrPend, entryHasData;
  logic [ID_W-1:0]   pendId, allocId, entryId, setPendId;
  logic [DATA_W-1:0] pendData, entryData;

  irq_seq_ctrl #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .DATA_W(DATA_W)) ctrl_i (
    .clk, .rstN, .reqValid, .reqOp, .reqArg,
    .swAllowed, .pendAny, .pendId, .pendData, .pendHasData, .allocOk, .allocId,
    .st, .reqAck, .reqResult, .irqEnable, .busy,
    .entryId, .entryData, .entryHasData, .setPendSw, .setPendId, .clrPend, .allocDo
  );

  irq_slot_table #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .DATA_W(DATA_W)) table_i (
    .clk, .rstN, .allocDo, .allocCfg(reqArg[1:0]), .swId(reqArg[ID_W-1:0]),
    .busIrq, .busId(busIrqId), .busData(busIrqData),
    .setPendSw, .setPendId, .clrPend, .clrPendId(pendId),
    .allocOk, .allocId, .swAllowed, .pendAny, .pendId, .pendData, .pendHasData
  );

  irq_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
    .START_ADDR(START_ADDR), .STACK_ADDR(STACK_ADDR), .VEC_ADDR(VEC_ADDR)
  ) dp_i (
    .clk, .rstN, .st, .memRdata, .curPc, .entryId, .entryData, .entryHasData,
    .memAddr, .memRd, .memWr, .memWdata, .pcLoad, .pcValue,
    .stackPtr, .intType, .intData, .bankEn
  );

endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  reqOp;
  logic [7:0]  reqArg;
  logic        reqAck;
  logic [7:0]  reqResult;
  logic [15:0] curPc;
  logic        busIrq;
  logic [3:0]  busIrqId;
  logic [7:0]  busIrqData;
  logic [15:0] memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;
  logic        pcLoad;
  logic [15:0] pcValue;
  logic [7:0]  stackPtr, intType, intData;
  logic        bankEn, irqEnable, busy;

  always #4 clk = ~clk;

  irq_entry_seq dut_i (
    .clk, .rstN, .reqValid, .reqOp, .reqArg, .reqAck, .reqResult, .curPc,
    .busIrq, .busIrqId, .busIrqData, .memAddr, .memRd, .memWr, .memWdata, .memRdata,
    .pcLoad, .pcValue, .stackPtr, .intType, .intData, .bankEn, .irqEnable, .busy
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
  } ev_t;

  ev_t        expQ[$];
  logic [7:0] mem [256];
  int         nRun = 0;
  int         nFail = 0;
  int         spModel = 0;

  always @(posedge clk) if (memRd) memRdata <= mem[memAddr[7:0]];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmpEvent(input logic [1:0] kind, input logic [15:0] addr, input logic [7:0] data);
    ev_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R8 unexpected memory/pc event", int'(addr), -1);
    end else begin
      e = expQ.pop_front();
      check(e.kind == kind && e.addr == addr && e.data == data,
            "R4 scoreboard event", int'({kind, addr, data}), int'({e.kind, e.addr, e.data}));
    end
  endtask

  // monitor: compares observed events against the expected queue
  always @(negedge clk) begin
    if (rstN) begin
      if (memRd)  cmpEvent(2'd0, memAddr, 8'h00);
      if (memWr)  cmpEvent(2'd1, memAddr, memWdata);
      if (pcLoad) cmpEvent(2'd2, pcValue, 8'h00);
    end
  end

  task automatic expRd(input int a);
    expQ.push_back(ev_t'{2'd0, 16'(a), 8'h00});
  endtask

  task automatic expEntry(input int base, input int pc, input int handler);
    expRd(2); expRd(3); expRd(4); expRd(5);
    expQ.push_back(ev_t'{2'd1, 16'(base + spModel), 8'(pc)});
    expQ.push_back(ev_t'{2'd1, 16'(base + spModel + 1), 8'(pc >> 8)});
    expQ.push_back(ev_t'{2'd2, 16'(handler), 8'h00});
    spModel += 2;
  endtask

  task automatic request(input int op, input int arg, output int res, output int cyc);
    @(posedge clk); #1;
    reqValid = 1'b1; reqOp = 3'(op); reqArg = 8'(arg);
    cyc = 0; res = -1;
    forever begin
      @(negedge clk);
      if (reqAck) begin res = int'(reqResult); break; end
      cyc++;
      if (cyc > 60) break;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy && expQ.size() == 0) break;
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9 expected events all seen", expQ.size(), 0);
  endtask

  task automatic pulseBus(input int id, input int data);
    @(posedge clk); #1;
    busIrq = 1'b1; busIrqId = 4'(id); busIrqData = 8'(data);
    @(posedge clk); #1;
    busIrq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int res, cyc;
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqArg = '0; curPc = 16'h1357;
    busIrq = 1'b0; busIrqId = '0; busIrqData = '0; memRdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5C);
    mem[0] = 8'hCD; mem[1] = 8'hAB; mem[2] = 8'h40; mem[3] = 8'h00;
    mem[4] = 8'h34; mem[5] = 8'h12;

    repeat (3) @(negedge clk);
    // R2 reset state
    check(irqEnable == 0 && bankEn == 0, "R2 enable/bank in reset", {irqEnable, bankEn}, 0);
    check(intType == 0 && intData == 0 && stackPtr == 0, "R2 regs in reset",
          {intType, intData, stackPtr}, 0);

    // R1 boot
    expRd(0); expRd(1);
    expQ.push_back(ev_t'{2'd2, 16'hABCD, 8'h00});
    @(posedge clk); #1 rstN = 1'b1;
    waitIdle();
    check(!busy, "R1 idle after boot", busy, 0);

    // R3 registration
    request(1, 1, res, cyc);
    check(res == 1 && cyc == 1, "R3 first id sw-only", (res << 8) | cyc, 16'h0101);
    request(1, 2, res, cyc);
    check(res == 2, "R3 second id bus-only", res, 2);
    request(1, 3, res, cyc);
    check(res == 3, "R3 third id both", res, 3);

    // R11 enable
    request(3, 0, res, cyc);
    check(cyc == 0, "R11 enable acked at once", cyc, 0);
    @(negedge clk);
    check(irqEnable == 1, "R11 enable set", irqEnable, 1);

    // R8 ignored software requests
    request(0, 5, res, cyc);
    check(cyc == 0, "R8 unregistered id ack", cyc, 0);
    request(0, 2, res, cyc);
    check(cyc == 0, "R8 bus-only id via software", cyc, 0);
    request(0, 8'h11, res, cyc);
    check(cyc == 0, "R8 upper nibble set", cyc, 0);
    repeat (3) @(negedge clk);
    check(!busy && stackPtr == 0, "R8 no entry started", {busy, stackPtr}, 0);

    // R7 software entry, R4 sequence, R5/R6 results
    expEntry(16'h0040, 16'h1357, 16'h1234);
    request(0, 1, res, cyc);
    check(cyc == 6, "R7 software entry ack latency", cyc, 6);
    @(negedge clk);
    check(intType == 8'h10, "R5 intType id1", intType, 8'h10);
    check(bankEn == 1 && irqEnable == 0, "R5 bank on, enable off", {bankEn, irqEnable}, 2);
    check(intData == 0, "R6 software entry keeps intData", intData, 0);
    check(stackPtr == 2, "R4 stack pointer advanced", stackPtr, 2);
    waitIdle();

    // R9 pending while disabled; R4 vectors re-read with new base
    mem[2] = 8'h60;
    curPc = 16'h2468;
    pulseBus(2, 8'h5A);
    pulseBus(1, 8'h77);
    request(0, 3, res, cyc);
    check(cyc == 0, "R9 pended software ack at once", cyc, 0);
    repeat (3) @(negedge clk);
    check(!busy, "R9 nothing entered while disabled", busy, 0);
    expEntry(16'h0060, 16'h2468, 16'h1234);
    request(3, 0, res, cyc);
    waitIdle();
    check(intType == 8'h20, "R9 lowest pending id first", intType, 8'h20);
    check(intData == 8'h5A, "R6 bus data captured", intData, 8'h5A);
    expEntry(16'h0060, 16'h2468, 16'h1234);
    request(3, 0, res, cyc);
    waitIdle();
    check(intType == 8'h30, "R9 second pending id", intType, 8'h30);
    check(intData == 8'h5A, "R6 soft entry keeps bus data", intData, 8'h5A);
    request(3, 0, res, cyc);
    repeat (6) @(negedge clk);
    check(!busy && stackPtr == 6, "R8 bus event on sw-only id ignored", stackPtr, 6);

    // R10 invalid-instruction trap
    curPc = 16'h0F0E;
    expEntry(16'h0060, 16'h0F0E, 16'h1234);
    request(4, 0, res, cyc);
    check(cyc == 6, "R10 trap ack latency", cyc, 6);
    @(negedge clk);
    check(intType == 8'h00 && bankEn == 1, "R10 trap id zero", intType, 0);
    waitIdle();

    // R11 disable
    request(3, 0, res, cyc);
    request(2, 0, res, cyc);
    check(cyc == 0, "R11 disable acked at once", cyc, 0);
    @(negedge clk);
    check(irqEnable == 0, "R11 enable cleared", irqEnable, 0);

    // R3 exhaustion
    for (int k = 4; k < 16; k++) begin
      request(1, 0, res, cyc);
      check(res == k, "R3 sequential allocation", res, k);
    end
    request(1, 3, res, cyc);
    check(res == 8'hFF && cyc == 1, "R3 full table result", res, 8'hFF);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule